// File: doc/BRIEF.md
# Systolic Integral Image Array

This block turns a small rectangular pixel window into two summed-area tables in one pass: the integral image, where each cell holds the sum of every pixel at or above and at or left of it, and the squared integral image, which holds the same sums over squared pixels. A one-cycle start pulse captures the whole window from a flat input bus. The start pulse also clears every stored sum and launches a fixed-length run. When the run completes, a one-cycle done pulse marks it, and both tables can be read from registered output buses.

The work is spread over a grid of processing elements with one element per window cell. In the first phase, each grid row receives a stream of tokens on a shift lane, one element per cycle. Raw and squared pixel values alternate on that stream, and each token is tagged with its source column and its kind. An element adds a passing token into its own raw or squared sum only if the token's column is not to the right of the element's own column. It passes every token along regardless. After this phase, every element holds a row prefix sum. In the second phase, each row in turn, from top to bottom, adds the finished sums of the row above into its own sums, raw first and then squared. The rows that are not taking their step leave their sums unchanged. No element uses an adder tree; the only arithmetic is one adder per element and one squarer per row.

Top module: `iia_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, done_o and busy_o are 0 and every output sum is 0.
- R2: After the clock edge that samples start_i high, every cell of ii_o and sq_o reads 0 and busy_o is 1.
- R3: done_o goes high exactly RUN = 4*COLS + 2*ROWS - 4 clock edges after the edge that samples start_i. It stays high for one cycle only, and busy_o falls at the same edge.
- R4: After done, the cell at row r, column c of ii_o equals the sum of every pixel (i, j) with i <= r and j <= c. Pixel (r, c) occupies win_i bits [(r*COLS+c)*PW +: PW]. Cell (r, c) occupies ii_o bits [(r*COLS+c)*SW +: SW], where SW = PW + clog2(ROWS*COLS).
- R5: After done, cell (r, c) of sq_o equals the sum of the squares of the same pixels. It occupies sq_o bits [(r*COLS+c)*QW +: QW], where QW = 2*PW + clog2(ROWS*COLS).
- R6: Once done has fired, both output buses hold their values until the next start, whatever win_i does.
- R7: A start during a run aborts that run. The block captures the new window, clears the sums, and completes after a full RUN edges with the new window's results.
- R8: A window with every pixel at its maximum value gives ROWS*COLS*(2^PW-1) in the bottom-right cell of ii_o and ROWS*COLS*(2^PW-1)^2 in the bottom-right cell of sq_o, with no wrap-around.
- R9: Changes on win_i after the start edge have no effect on the results of the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: capture window, clear sums, begin run |
| win_i | input | ROWS*COLS*PW | Window pixels, row-major, column 0 of row 0 in the low bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| ii_o | output | ROWS*COLS*SW | Integral image, row-major |
| sq_o | output | ROWS*COLS*QW | Squared integral image, row-major |

## Verification
The bench builds the block with a window of 3 rows by 5 columns of 8-bit pixels. This gives a run of 22 cycles. Because the grid is not square, a swap of the row and column roles in the addressing or in the operation select would show up as wrong sums. Because 5 is not a power of two, the column tag has spare codes that must never be treated as valid columns. Fifteen cells also make the all-maximum window reach 3825 and 975375, which probes the derived sum widths near their limits.

// File: rtl/iia_pkg.sv
`timescale 1ns/1ps
package iia_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HORZ = 2'd1,
    PH_VERT = 2'd2
  } phase_e;

  // width of a raw-pixel sum over a whole window
  function automatic int raw_w(input int pw, input int cells);
    return pw + $clog2(cells);
  endfunction

  // width of a squared-pixel sum over a whole window
  function automatic int sq_w(input int pw, input int cells);
    return 2 * pw + $clog2(cells);
  endfunction

  // edges from the start edge to the done edge
  function automatic int run_len(input int rows, input int cols);
    return 4 * cols + 2 * rows - 4;
  endfunction

endpackage

// File: rtl/iia_seq.sv
`timescale 1ns/1ps
module iia_seq
  import iia_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int CW   = 2,
  parameter int RW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          feed_en_o,
  output logic [CW-1:0] feed_col_o,
  output logic          feed_sq_o,
  output logic          vert_en_o,
  output logic [RW-1:0] vert_row_o,
  output logic          vert_sq_o
);

  localparam int TOTAL = run_len(ROWS, COLS);
  localparam int HLEN  = 4 * COLS - 2;
  localparam int FEED  = 2 * COLS;
  localparam int CNTW  = $clog2(TOTAL + 1);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] vs;
  phase_e          ph_q;
  logic            done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        ph_q  <= PH_HORZ;
        cnt_q <= '0;
      end else if (ph_q != PH_IDLE) begin
        if (cnt_q == CNTW'(TOTAL - 1)) begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNTW'(HLEN - 1)) ph_q <= PH_VERT;
        end
      end
    end
  end

  assign vs         = cnt_q - CNTW'(HLEN);
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = done_q;
  assign feed_en_o  = (ph_q == PH_HORZ) && (cnt_q < CNTW'(FEED));
  assign feed_col_o = CW'(cnt_q >> 1);
  assign feed_sq_o  = cnt_q[0];
  assign vert_en_o  = (ph_q == PH_VERT);
  assign vert_row_o = RW'(vs[CNTW-1:1] + 1'b1);
  assign vert_sq_o  = vs[0];

endmodule

// File: rtl/iia_feed.sv
`timescale 1ns/1ps
module iia_feed #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int PW   = 8,
  parameter int QW   = 20,
  parameter int CW   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [ROWS*COLS*PW-1:0] win_i,
  input  logic [CW-1:0]           feed_col_i,
  input  logic                    feed_sq_i,
  output logic [ROWS*QW-1:0]      val_o
);

  logic [ROWS*COLS*PW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst)          win_q <= '0;
    else if (start_i) win_q <= win_i;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [PW-1:0]   pix;
    logic [2*PW-1:0] sqr;
    assign pix = win_q[(r * COLS + int'(feed_col_i)) * PW +: PW];
    assign sqr = pix * pix;
    assign val_o[r*QW +: QW] = feed_sq_i ? QW'(sqr) : QW'(pix);
  end

endmodule

// File: rtl/iia_lane.sv
`timescale 1ns/1ps
module iia_lane #(
  parameter int COLS = 4,
  parameter int QW   = 20,
  parameter int CW   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [QW-1:0]      val_i,
  input  logic [CW-1:0]      idx_i,
  input  logic               sq_i,
  input  logic               vld_i,
  output logic [COLS*QW-1:0] val_o,
  output logic [COLS*CW-1:0] idx_o,
  output logic [COLS-1:0]    sq_o,
  output logic [COLS-1:0]    vld_o
);

  logic [QW-1:0] val_q [COLS];
  logic [CW-1:0] idx_q [COLS];
  logic          sq_q  [COLS];
  logic          vld_q [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_stage
    if (c == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          val_q[c] <= '0;
          idx_q[c] <= '0;
          sq_q[c]  <= 1'b0;
          vld_q[c] <= 1'b0;
        end else begin
          val_q[c] <= val_i;
          idx_q[c] <= idx_i;
          sq_q[c]  <= sq_i;
          vld_q[c] <= vld_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          val_q[c] <= '0;
          idx_q[c] <= '0;
          sq_q[c]  <= 1'b0;
          vld_q[c] <= 1'b0;
        end else begin
          val_q[c] <= val_q[c-1];
          idx_q[c] <= idx_q[c-1];
          sq_q[c]  <= sq_q[c-1];
          vld_q[c] <= vld_q[c-1];
        end
      end
    end
    assign val_o[c*QW +: QW] = val_q[c];
    assign idx_o[c*CW +: CW] = idx_q[c];
    assign sq_o[c]           = sq_q[c];
    assign vld_o[c]          = vld_q[c];
  end

endmodule

// File: rtl/iia_pe.sv
`timescale 1ns/1ps
module iia_pe #(
  parameter int SW  = 12,
  parameter int QW  = 20,
  parameter int CW  = 2,
  parameter int COL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [QW-1:0] tok_val_i,
  input  logic [CW-1:0] tok_idx_i,
  input  logic          tok_sq_i,
  input  logic          tok_vld_i,
  input  logic [SW-1:0] up_raw_i,
  input  logic [QW-1:0] up_sq_i,
  input  logic          vert_en_i,
  input  logic          vert_sq_i,
  output logic [SW-1:0] raw_o,
  output logic [QW-1:0] sq_o
);

  localparam logic [CW-1:0] MY_COL = CW'(COL);

  logic [SW-1:0] raw_q;
  logic [QW-1:0] sq_q;
  logic          take;

  // column-dependent select: absorb tokens from this column or any left of it
  assign take = tok_vld_i && (tok_idx_i <= MY_COL);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      raw_q <= '0;
      sq_q  <= '0;
    end else if (vert_en_i) begin
      if (vert_sq_i) sq_q  <= sq_q + up_sq_i;
      else           raw_q <= raw_q + up_raw_i;
    end else if (take) begin
      if (tok_sq_i) sq_q  <= sq_q + tok_val_i;
      else          raw_q <= raw_q + tok_val_i[SW-1:0];
    end
  end

  assign raw_o = raw_q;
  assign sq_o  = sq_q;

endmodule

// File: rtl/iia_top.sv
`timescale 1ns/1ps
module iia_top
  import iia_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int PW   = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int SW    = raw_w(PW, CELLS),
  localparam int QW    = sq_w(PW, CELLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CELLS*PW-1:0] win_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CELLS*SW-1:0] ii_o,
  output logic [CELLS*QW-1:0] sq_o
);

  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic          feed_en;
  logic [CW-1:0] feed_col;
  logic          feed_sq;
  logic          vert_en;
  logic [RW-1:0] vert_row;
  logic          vert_sq;
  logic [ROWS*QW-1:0] feed_val;

  logic [SW-1:0] raw_s [ROWS][COLS];
  logic [QW-1:0] sq_s  [ROWS][COLS];

  iia_seq #(.ROWS(ROWS), .COLS(COLS), .CW(CW), .RW(RW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .feed_en_o  (feed_en),
    .feed_col_o (feed_col),
    .feed_sq_o  (feed_sq),
    .vert_en_o  (vert_en),
    .vert_row_o (vert_row),
    .vert_sq_o  (vert_sq)
  );

  iia_feed #(.ROWS(ROWS), .COLS(COLS), .PW(PW), .QW(QW), .CW(CW)) u_feed (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .win_i      (win_i),
    .feed_col_i (feed_col),
    .feed_sq_i  (feed_sq),
    .val_o      (feed_val)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    logic [COLS*QW-1:0] l_val;
    logic [COLS*CW-1:0] l_idx;
    logic [COLS-1:0]    l_sq;
    logic [COLS-1:0]    l_vld;
    logic               row_step;

    if (r == 0) begin : g_top_row
      assign row_step = 1'b0;
    end else begin : g_lower_row
      assign row_step = vert_en && (vert_row == RW'(r));
    end

    iia_lane #(.COLS(COLS), .QW(QW), .CW(CW)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .clr   (start_i),
      .val_i (feed_val[r*QW +: QW]),
      .idx_i (feed_col),
      .sq_i  (feed_sq),
      .vld_i (feed_en),
      .val_o (l_val),
      .idx_o (l_idx),
      .sq_o  (l_sq),
      .vld_o (l_vld)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_c
      logic [SW-1:0] up_raw;
      logic [QW-1:0] up_sq;

      if (r == 0) begin : g_no_up
        assign up_raw = '0;
        assign up_sq  = '0;
      end else begin : g_up
        assign up_raw = raw_s[r-1][c];
        assign up_sq  = sq_s[r-1][c];
      end

      iia_pe #(.SW(SW), .QW(QW), .CW(CW), .COL(c)) u_pe (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_i),
        .tok_val_i (l_val[c*QW +: QW]),
        .tok_idx_i (l_idx[c*CW +: CW]),
        .tok_sq_i  (l_sq[c]),
        .tok_vld_i (l_vld[c]),
        .up_raw_i  (up_raw),
        .up_sq_i   (up_sq),
        .vert_en_i (row_step),
        .vert_sq_i (vert_sq),
        .raw_o     (raw_s[r][c]),
        .sq_o      (sq_s[r][c])
      );

      assign ii_o[(r*COLS+c)*SW +: SW] = raw_s[r][c];
      assign sq_o[(r*COLS+c)*QW +: QW] = sq_s[r][c];
    end
  end

endmodule

// File: rtl/iia_chk.sv
`timescale 1ns/1ps
module iia_chk
  import iia_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int PW   = 8,
  localparam int CELLS = ROWS * COLS,
  localparam int SW    = raw_w(PW, CELLS),
  localparam int QW    = sq_w(PW, CELLS)
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [CELLS*SW-1:0] ii_o,
  input logic [CELLS*QW-1:0] sq_o
);

  localparam int  RUN     = run_len(ROWS, COLS);
  localparam longint PMAX = (64'd1 << PW) - 1;
  localparam logic [SW-1:0] RAW_CAP = SW'(CELLS * PMAX);
  localparam logic [QW-1:0] SQ_CAP  = QW'(CELLS * PMAX * PMAX);

  logic [15:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)          lat_q <= '0;
    else if (start_i) lat_q <= '0;
    else if (busy_o)  lat_q <= lat_q + 1'b1;
  end

  // R1: reset leaves the block idle with cleared sums
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_o && !busy_o && ii_o == '0 && sq_o == '0));

  // R2: a start clears the sums and raises busy
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && ii_o == '0 && sq_o == '0));

  // R3: done arrives exactly RUN edges after start
  a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == 16'(RUN)));

  // R3: done is a single-cycle pulse and busy has dropped
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o ##1 !done_o));

  // R6: sums are frozen while idle
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(ii_o) && $stable(sq_o)));

  // R8: the largest cell never exceeds the full-scale total
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ii_o[(CELLS-1)*SW +: SW] <= RAW_CAP &&
                sq_o[(CELLS-1)*QW +: QW] <= SQ_CAP));

endmodule

bind iia_top iia_chk #(.ROWS(ROWS), .COLS(COLS), .PW(PW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ii_o    (ii_o),
  .sq_o    (sq_o)
);

// File: tb/iia_top_tb_top.sv
`timescale 1ns/1ps
module iia_top_tb_top;

  localparam int ROWS  = 3;
  localparam int COLS  = 5;
  localparam int PW    = 8;
  localparam int CELLS = ROWS * COLS;
  localparam int SW    = PW + $clog2(CELLS);
  localparam int QW    = 2 * PW + $clog2(CELLS);
  localparam int RUN   = 4 * COLS + 2 * ROWS - 4;
  localparam int WB    = CELLS * PW;
  localparam int NVEC  = 5;

  localparam logic [WB-1:0] VEC [NVEC] = '{
    120'h0123456789abcdef0fedcba9876543,
    120'hff00ff00ff00ff00ff00ff00ff00ff,
    120'h0102030405060708090a0b0c0d0e0f,
    120'h8040201008040201804020100804ff,
    120'h5a5a5a5aa5a5a5a53c3c3cc3c3c3c3
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start_i = 1'b0;
  logic [WB-1:0]       win_i = '0;
  logic                busy_o;
  logic                done_o;
  logic [CELLS*SW-1:0] ii_o;
  logic [CELLS*QW-1:0] sq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iia_top #(.ROWS(ROWS), .COLS(COLS), .PW(PW)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .win_i   (win_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ii_o    (ii_o),
    .sq_o    (sq_o)
  );

  function automatic longint ref_sum(input logic [WB-1:0] w, input int r,
                                     input int c, input bit sq);
    longint acc = 0;
    for (int i = 0; i <= r; i++)
      for (int j = 0; j <= c; j++) begin
        longint p = longint'(w[(i*COLS+j)*PW +: PW]);
        acc += sq ? p * p : p;
      end
    return acc;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_tables(input logic [WB-1:0] w, input string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        check({req, " ii"}, longint'(ii_o[(r*COLS+c)*SW +: SW]), ref_sum(w, r, c, 1'b0));
        check({req, " sq"}, longint'(sq_o[(r*COLS+c)*QW +: QW]), ref_sum(w, r, c, 1'b1));
      end
  endtask

  task automatic check_zero(input string req);
    check({req, " ii zero"}, longint'(ii_o == '0), 1);
    check({req, " sq zero"}, longint'(sq_o == '0), 1);
  endtask

  // leaves the bench at the negedge right after the start edge
  task automatic launch(input logic [WB-1:0] w);
    @(negedge clk);
    win_i   = w;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // from the negedge after the start edge, checks done timing
  task automatic wait_done(input string req);
    repeat (RUN - 1) @(negedge clk);
    check({req, " done early"}, longint'(done_o), 0);
    @(negedge clk);
    check({req, " done at RUN"}, longint'(done_o), 1);
    check({req, " busy low at done"}, longint'(busy_o), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [WB-1:0] all_max;
    all_max = '1;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", longint'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", longint'(done_o), 0);
    check("R1 busy after reset", longint'(busy_o), 0);
    check_zero("R1");

    // table walk: R2 clear, R3 timing, R4/R5 values, R6 hold
    for (int v = 0; v < NVEC; v++) begin
      launch(VEC[v]);
      check("R2 busy after start", longint'(busy_o), 1);
      check_zero("R2");
      wait_done("R3");
      check_tables(VEC[v], "R4 R5");
      @(negedge clk);
      check("R3 done single cycle", longint'(done_o), 0);
      win_i = ~VEC[v];
      repeat (4) @(negedge clk);
      check_tables(VEC[v], "R6 hold");
    end

    // R8: full-scale window
    launch(all_max);
    wait_done("R8");
    check("R8 ii corner", longint'(ii_o[(CELLS-1)*SW +: SW]), longint'(CELLS * 255));
    check("R8 sq corner", longint'(sq_o[(CELLS-1)*QW +: QW]), longint'(CELLS * 65025));
    check_tables(all_max, "R8");

    // R9: window bus changes mid-run are ignored
    launch(VEC[0]);
    repeat (3) @(negedge clk);
    win_i = VEC[1];
    repeat (RUN - 4) @(negedge clk);
    check("R9 done early", longint'(done_o), 0);
    @(negedge clk);
    check("R9 done", longint'(done_o), 1);
    check_tables(VEC[0], "R9");

    // R7: restart during a run
    launch(VEC[3]);
    repeat (6) @(negedge clk);
    launch(VEC[2]);
    check_zero("R7 restart clear");
    wait_done("R7");
    check_tables(VEC[2], "R7");

    // R2: zero window after a nonzero one
    launch('0);
    wait_done("R2 zero window");
    check_zero("R2 zero window result");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule